// File: doc/BRIEF.md
# Trigger Queue Choke and Error Monitor

This block holds the pending trigger requests of two independent processing halves, one queue per half, and watches how full those queues get. It also watches the ready line of the memory controller. From these inputs it derives two sticky warning flags for the central trigger processor. The choke flag asks the processor to stop sending triggers. The error flag reports that a queue has overflowed its capacity or that the memory has become unavailable.

Each queue accepts requests on a valid/ready write stream and returns them, in order, on a valid/ready read stream. A write is taken when both `wr_valid` and `wr_ready` are high for that lane. `wr_ready` drops only when the queue is full. A write offered while the queue is full is discarded rather than stalled, and it is counted in a per-lane saturating drop counter. A read is taken when both `rd_valid` and `rd_ready` are high. `rd_data` shows the head entry whenever `rd_valid` is high.

The choke threshold is an input, so it can be tuned to the reaction delay of the trigger processor. Each flag clears only on its own acknowledge trigger, and the clear takes effect at once, with no added latency.

Top module: `trigq_choke_monitor`

## Requirements
- R1: After reset both flags are low, both queues are empty (`rd_valid` low, `wr_ready` high) and both drop counters read zero.
- R2: Each lane is a first-in first-out queue of 64 entries. Entries leave in the order they were accepted. A write and a read in the same cycle on a lane both take effect.
- R3: `wr_ready` of a lane is low exactly while that lane holds 64 entries. A write offered while the lane is full is discarded, and the stored entries stay unchanged.
- R4: Each discarded write adds one to that lane's drop counter (8 bits per lane, lane n at bits [8n+7:8n] of `drop_cnt`). The counter saturates at 255.
- R5: The choke flag goes high one clock edge after the edge at which a lane's stored entry count first exceeds `choke_thresh`.
- R6: The threshold is taken from the `choke_thresh` input. A count equal to the threshold does not raise the choke flag. The reset-time working value is 32.
- R7: The error flag goes high one clock edge after the edge at which a lane becomes full.
- R8: The error flag goes high at the clock edge that samples `mem_ready` low.
- R9: `choke_ack` high at an edge clears the choke flag at that edge, and `error_ack` does the same for the error flag. Neither acknowledge affects the other flag.
- R10: Both flags are sticky: once set, a flag stays high until its acknowledge, even after its cause goes away. If a set cause is present in the same cycle as the acknowledge, the flag reads low after that edge and high again after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 2 | Write request, one bit per lane |
| wr_data | input | 32 | Write payload, 16 bits per lane |
| wr_ready | output | 2 | Lane not full |
| rd_valid | output | 2 | Lane holds at least one entry |
| rd_data | output | 32 | Head entry, 16 bits per lane |
| rd_ready | input | 2 | Consumer takes the head entry |
| choke_thresh | input | 7 | Choke threshold; a count above it raises choke |
| mem_ready | input | 1 | Memory controller ready; low raises error |
| choke_ack | input | 1 | Trigger that clears the choke flag |
| error_ack | input | 1 | Trigger that clears the error flag |
| choke_flag | output | 1 | Sticky choke request |
| error_flag | output | 1 | Sticky error report |
| drop_cnt | output | 16 | Saturating count of discarded writes, 8 bits per lane |

## Verification
The two functions that can meet in one cycle are the setting of a flag and its acknowledge. The bench creates this collision in two ways. In the first, it pulses `error_ack` while `mem_ready` is held low. In the second, it pulses `choke_ack` while a lane sits above the threshold. In both cases it expects the flag to read low right after that edge and high after the next one. A second overlap, a write and a read on the same lane in the same cycle, is judged by the order and count of the entries that are later drained.

// File: rtl/trigq_pkg.sv
package trigq_pkg;
  localparam int unsigned LANES_DEF  = 2;
  localparam int unsigned DEPTH_DEF  = 64;
  localparam int unsigned DATA_W_DEF = 16;
  localparam int unsigned DROP_W_DEF = 8;

  // width of an occupancy value able to hold 0..depth
  function automatic int unsigned level_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

  // advance a ring index, wrapping after the last slot
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/trigq_lane_fifo.sv
module trigq_lane_fifo
  import trigq_pkg::*;
#(
  parameter int unsigned DEPTH  = DEPTH_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned CW     = level_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rd_ready,
  output logic [CW-1:0]     level,
  output logic              full,
  output logic              drop
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              push, pop;

  assign full     = (level == CW'(DEPTH));
  assign wr_ready = !full;
  assign rd_valid = (level != '0);
  assign rd_data  = mem[rptr];
  assign push     = wr_valid && !full;
  assign pop      = rd_ready && rd_valid;
  assign drop     = wr_valid && full;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= AW'(ring_next(32'(wptr), DEPTH));
      if (pop)  rptr <= AW'(ring_next(32'(rptr), DEPTH));
      case ({push, pop})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/trigq_sat_counter.sv
module trigq_sat_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)                  value <= '0;
    else if (inc && value != '1) value <= value + W'(1);
  end
endmodule

// File: rtl/trigq_sticky_flag.sv
module trigq_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_cond,
  input  logic clear,
  output logic flag
);
  logic rearm;

  // a cause seen during a clear is remembered and re-sets the flag next edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      rearm <= 1'b0;
    end else begin
      rearm <= clear && set_cond;
      flag  <= clear ? 1'b0 : (flag || set_cond || rearm);
    end
  end
endmodule

// File: rtl/trigq_choke_monitor.sv
module trigq_choke_monitor
  import trigq_pkg::*;
#(
  parameter int unsigned LANES  = LANES_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned DROP_W = DROP_W_DEF,
  parameter int unsigned CW     = level_width(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        wr_valid,
  input  logic [LANES*DATA_W-1:0] wr_data,
  output logic [LANES-1:0]        wr_ready,
  output logic [LANES-1:0]        rd_valid,
  output logic [LANES*DATA_W-1:0] rd_data,
  input  logic [LANES-1:0]        rd_ready,
  input  logic [CW-1:0]           choke_thresh,
  input  logic                    mem_ready,
  input  logic                    choke_ack,
  input  logic                    error_ack,
  output logic                    choke_flag,
  output logic                    error_flag,
  output logic [LANES*DROP_W-1:0] drop_cnt
);
  logic [LANES-1:0] lane_above, lane_full, lane_drop;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [CW-1:0] lvl;

    trigq_lane_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CW(CW)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid[l]),
      .wr_data  (wr_data[l*DATA_W +: DATA_W]),
      .wr_ready (wr_ready[l]),
      .rd_valid (rd_valid[l]),
      .rd_data  (rd_data[l*DATA_W +: DATA_W]),
      .rd_ready (rd_ready[l]),
      .level    (lvl),
      .full     (lane_full[l]),
      .drop     (lane_drop[l])
    );

    trigq_sat_counter #(.W(DROP_W)) u_drops (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (lane_drop[l]),
      .value (drop_cnt[l*DROP_W +: DROP_W])
    );

    // compares the registered occupancy, so the flag lags it by one edge
    assign lane_above[l] = (lvl > choke_thresh);
  end

  trigq_sticky_flag u_choke (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_cond (|lane_above),
    .clear    (choke_ack),
    .flag     (choke_flag)
  );

  trigq_sticky_flag u_error (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_cond ((|lane_full) || !mem_ready),
    .clear    (error_ack),
    .flag     (error_flag)
  );
endmodule

// File: rtl/trigq_choke_monitor_chk.sv
module trigq_choke_monitor_chk #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned DROP_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LANES-1:0]        wr_valid,
  input logic [LANES-1:0]        wr_ready,
  input logic [LANES-1:0]        rd_valid,
  input logic [LANES-1:0]        rd_ready,
  input logic                    mem_ready,
  input logic                    choke_ack,
  input logic                    error_ack,
  input logic                    choke_flag,
  input logic                    error_flag,
  input logic [LANES*DROP_W-1:0] drop_cnt
);
  logic err_hit_in_clear;

  always_ff @(posedge clk) begin
    if (!rst_n) err_hit_in_clear <= 1'b0;
    else        err_hit_in_clear <= error_ack && !mem_ready;
  end

  // R9
  choke_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    choke_ack |=> !choke_flag);

  // R9
  error_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error_ack |=> !error_flag);

  // R8
  mem_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ready && !error_ack) |=> error_flag);

  // R10
  choke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (choke_flag && !choke_ack) |=> choke_flag);

  // R10
  error_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_hit_in_clear && !error_ack) |=> error_flag);

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    // R4
    drop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid[l] && !wr_ready[l] && drop_cnt[l*DROP_W +: DROP_W] != '1)
      |=> drop_cnt[l*DROP_W +: DROP_W] == $past(drop_cnt[l*DROP_W +: DROP_W]) + DROP_W'(1));

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_ready[l] && !(rd_valid[l] && rd_ready[l])) |=> !wr_ready[l]);
  end
endmodule

bind trigq_choke_monitor trigq_choke_monitor_chk #(.LANES(LANES), .DROP_W(DROP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .mem_ready  (mem_ready),
  .choke_ack  (choke_ack),
  .error_ack  (error_ack),
  .choke_flag (choke_flag),
  .error_flag (error_flag),
  .drop_cnt   (drop_cnt)
);

// File: tb/trigq_choke_monitor_tb.sv
module trigq_choke_monitor_tb;
  localparam int PERIOD = 10;
  localparam int LANES  = 2;
  localparam int DEPTH  = 64;
  localparam int DW     = 16;
  localparam int DROPW  = 8;
  localparam int CW     = 7;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [LANES-1:0]       wr_valid = '0;
  logic [LANES*DW-1:0]    wr_data = '0;
  logic [LANES-1:0]       wr_ready;
  logic [LANES-1:0]       rd_valid;
  logic [LANES*DW-1:0]    rd_data;
  logic [LANES-1:0]       rd_ready = '0;
  logic [CW-1:0]          choke_thresh = 7'd32;
  logic                   mem_ready = 1'b1;
  logic                   choke_ack = 1'b0;
  logic                   error_ack = 1'b0;
  logic                   choke_flag, error_flag;
  logic [LANES*DROPW-1:0] drop_cnt;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  trigq_choke_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ready(rd_ready), .choke_thresh(choke_thresh), .mem_ready(mem_ready),
    .choke_ack(choke_ack), .error_ack(error_ack), .choke_flag(choke_flag),
    .error_flag(error_flag), .drop_cnt(drop_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input int lane, input int data);
    wr_valid[lane] = 1'b1;
    wr_data[lane*DW +: DW] = DW'(data);
    tick();
    wr_valid[lane] = 1'b0;
  endtask

  task automatic pop_expect(input string req, input int lane, input int exp);
    chk({req, " rd_valid"}, int'(rd_valid[lane]), 1);
    chk({req, " rd_data"}, int'(rd_data[lane*DW +: DW]), exp);
    rd_ready[lane] = 1'b1;
    tick();
    rd_ready[lane] = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 choke", int'(choke_flag), 0);
    chk("R1 error", int'(error_flag), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 wr_ready", int'(wr_ready), 3);
    chk("R1 drop_cnt", int'(drop_cnt), 0);
  endtask

  task automatic t_order();
    push(1, 16'hA0); push(1, 16'hA1); push(1, 16'hA2);
    // R2 simultaneous read and write
    chk("R2 head", int'(rd_data[DW +: DW]), 16'hA0);
    rd_ready[1] = 1'b1; wr_valid[1] = 1'b1; wr_data[DW +: DW] = 16'hA3;
    tick();
    rd_ready[1] = 1'b0; wr_valid[1] = 1'b0;
    pop_expect("R2", 1, 16'hA1);
    pop_expect("R2", 1, 16'hA2);
    pop_expect("R2", 1, 16'hA3);
    chk("R2 empty", int'(rd_valid[1]), 0);
    chk("R2 no choke", int'(choke_flag), 0);
  endtask

  task automatic t_choke();
    for (int i = 0; i < 32; i++) push(0, i);
    tick();
    chk("R6 equal no choke", int'(choke_flag), 0);
    push(0, 32);
    chk("R5 choke latency", int'(choke_flag), 0);
    tick();
    chk("R5 choke set", int'(choke_flag), 1);
  endtask

  task automatic t_sticky_choke();
    choke_ack = 1'b1; tick(); choke_ack = 1'b0;
    chk("R9 choke cleared", int'(choke_flag), 0);
    tick();
    chk("R10 choke rearmed", int'(choke_flag), 1);
  endtask

  task automatic t_mem();
    mem_ready = 1'b0; tick(); mem_ready = 1'b1;
    chk("R8 error on mem", int'(error_flag), 1);
    tick();
    chk("R10 error sticky", int'(error_flag), 1);
    error_ack = 1'b1; tick(); error_ack = 1'b0;
    chk("R9 error cleared", int'(error_flag), 0);
    chk("R9 choke untouched", int'(choke_flag), 1);
    // R10 cause present during the clear
    error_ack = 1'b1; mem_ready = 1'b0; tick();
    error_ack = 1'b0; mem_ready = 1'b1;
    chk("R10 error low at clear", int'(error_flag), 0);
    tick();
    chk("R10 error reset after clear", int'(error_flag), 1);
    error_ack = 1'b1; tick(); error_ack = 1'b0;
    chk("R9 error cleared again", int'(error_flag), 0);
  endtask

  task automatic t_full();
    for (int i = 33; i < 64; i++) push(0, i);
    chk("R3 wr_ready low", int'(wr_ready[0]), 0);
    chk("R7 error latency", int'(error_flag), 0);
    tick();
    chk("R7 error on full", int'(error_flag), 1);
    for (int i = 0; i < 3; i++) push(0, 16'hDEAD);
    chk("R4 drops counted", int'(drop_cnt[DROPW-1:0]), 3);
    chk("R4 other lane", int'(drop_cnt[DROPW +: DROPW]), 0);
    for (int i = 0; i < 64; i++) pop_expect("R3", 0, i);
    chk("R3 drained", int'(rd_valid[0]), 0);
  endtask

  task automatic t_thresh();
    choke_ack = 1'b1; error_ack = 1'b1; tick();
    choke_ack = 1'b0; error_ack = 1'b0;
    tick();
    chk("R9 both clear", int'({choke_flag, error_flag}), 0);
    choke_thresh = 7'd5;
    for (int i = 0; i < 5; i++) push(1, i);
    tick();
    chk("R6 at new thresh", int'(choke_flag), 0);
    push(1, 5);
    tick();
    chk("R6 above new thresh", int'(choke_flag), 1);
    for (int i = 0; i < 6; i++) pop_expect("R6", 1, i);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 64; i++) push(1, i);
    wr_valid[1] = 1'b1;
    for (int i = 0; i < 260; i++) tick();
    wr_valid[1] = 1'b0;
    chk("R4 saturated", int'(drop_cnt[DROPW +: DROPW]), 255);
    chk("R4 lane0 kept", int'(drop_cnt[DROPW-1:0]), 3);
    pop_expect("R4 contents", 1, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_order();
    t_choke();
    t_sticky_choke();
    t_mem();
    t_full();
    t_thresh();
    t_saturate();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule